// File: doc/BRIEF.md
# Pixel Scan Burst Clock Generator

This block produces three burst clocks for a sensor that is read out one pixel at a time. They are a load clock, a shift clock and a sample clock. A single fast system clock drives the whole block. From it the block derives an internal base clock whose period is `DIV_RATIO` system clocks. Each pixel takes a frame of `FRAME_LEN` base periods, which is 32 by default. Each burst clock copies the base clock's high phase only inside its own window of that frame. Outside its window it stays low.

Every output pin is the Q of a flip-flop clocked by the system clock. The gating decision is made one system clock ahead and registered, so decode hazards never reach a pin. The cost is that all three bursts lag the exposed cycle index by the same single system clock. A scan-enable input starts and stops the scan. A one-cycle strobe marks the end of each pixel frame.

Top module: `pixscan_burst_gen`

## Requirements
- R1: `cycleIdx` counts 0 to 31 and advances once every `DIV_RATIO` system clocks. After 31 it wraps to 0, so consecutive pixel-done strobes are exactly 32*`DIV_RATIO` system clocks apart.
- R2: `loadClk` pulses once per base period in frame cycles 0 to 5, giving 6 rising edges per pixel frame, and is low in every other cycle.
- R3: `shiftClk` pulses only in frame cycle 8, giving 1 rising edge per pixel frame.
- R4: `sampleClk` pulses in frame cycles 15 through 30, giving 16 rising edges per pixel frame, and is low in cycles 0 to 14 and in cycle 31.
- R5: Each burst output is registered. A burst output that is high in a system cycle implies that `cycleIdx` in the previous system cycle lay inside that output's window. No two burst outputs are high together.
- R6: Every high pulse on a burst output lasts exactly `DIV_RATIO`/2 system clocks, which is one base-clock high phase. All outputs are low in the system cycle that follows a base-period end.
- R7: While `rst` is high, or while the block is idle with `scanEn` low, all three burst outputs and `pixelDone` are low and `cycleIdx` is 0.
- R8: `pixelDone` is high for exactly one system clock. That clock is the first one in which `cycleIdx` reads 0 after cycle 31 completes.
- R9: From idle, when `scanEn` is first sampled high at a clock edge, the frame starts at cycle 0. `loadClk` is still low after that edge and rises at the following edge.
- R10: When `scanEn` falls during a scan, the block finishes the current base period without cutting a pulse short. It then returns to idle, with `cycleIdx` at 0 and all outputs low, no later than `DIV_RATIO`+1 system clocks after the fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; runs at least twice the base-clock rate |
| rst | input | 1 | Synchronous reset, active high |
| scanEn | input | 1 | Starts or continues the pixel scan while high |
| loadClk | output | 1 | Registered load burst, frame cycles 0 to 5 |
| shiftClk | output | 1 | Registered shift burst, frame cycle 8 |
| sampleClk | output | 1 | Registered sample burst, frame cycles 15 to 30 |
| cycleIdx | output | $clog2(FRAME_LEN) | Current base-cycle index within the pixel frame |
| pixelDone | output | 1 | One-system-clock strobe after cycle 31 completes |

## Verification
On every cycle, the assertions check the following:
- the index stepping, wrapping and holding still (R1);
- that the bursts never overlap (R5);
- the exact high-pulse width and the low state after each base period (R6);
- the idle quiet state (R7);
- the single-cycle done strobe (R8);
- that the run state survives until a base-period boundary (R10).

Some behaviours show only across whole frames, so only the bench scenarios can demonstrate them. These are the per-frame pulse counts of 6, 1 and 16 (R2 to R4), the one-cycle lag of each burst behind the index (R5), the start latency after enable (R9), and the return to idle after enable drops mid-frame (R10).

// File: rtl/pixscan_pkg.sv
package pixscan_pkg;

  // Channel order used throughout: 0 = load, 1 = shift, 2 = sample
  localparam int unsigned NUM_CH = 3;

  typedef struct packed {
    logic running;    // scan active
    logic phaseHigh;  // base clock is in its high phase
    logic periodEnd;  // last system clock of a base period
    logic frameEnd;   // last system clock of the last base period of a frame
  } scanStrobe_t;

  function automatic int unsigned winLo(input int unsigned ch);
    case (ch)
      0:       return 0;
      1:       return 8;
      default: return 15;
    endcase
  endfunction

  function automatic int unsigned winHi(input int unsigned ch);
    case (ch)
      0:       return 5;
      1:       return 8;
      default: return 30;
    endcase
  endfunction

endpackage

// File: rtl/pixscan_ctrl.sv
module pixscan_ctrl
  import pixscan_pkg::*;
#(
  parameter int unsigned DIV_RATIO = 2,
  parameter int unsigned FRAME_LEN = 32,
  localparam int unsigned IDX_W = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scanEn,
  output scanStrobe_t      strb,
  output logic [IDX_W-1:0] cycleIdx
);

  localparam int unsigned PH_W = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
  localparam int unsigned HALF = DIV_RATIO / 2;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV_RATIO - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(HALF);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_LEN - 1);

  logic            run;
  logic [PH_W-1:0] phase;
  logic            atPeriodEnd;

  assign atPeriodEnd = run && (phase == PH_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      phase    <= '0;
      cycleIdx <= '0;
    end else if (!run) begin
      run      <= scanEn;
      phase    <= '0;
      cycleIdx <= '0;
    end else if (atPeriodEnd) begin
      phase <= '0;
      run   <= scanEn;
      if (!scanEn || cycleIdx == IDX_LAST) cycleIdx <= '0;
      else                                 cycleIdx <= cycleIdx + IDX_W'(1);
    end else begin
      phase <= phase + PH_W'(1);
    end
  end

  always_comb begin
    strb.running   = run;
    strb.phaseHigh = phase < PH_HALF;
    strb.periodEnd = atPeriodEnd;
    strb.frameEnd  = atPeriodEnd && (cycleIdx == IDX_LAST);
  end

  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (rst)
    strb.frameEnd |=> cycleIdx == '0); // R1
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (strb.periodEnd && !strb.frameEnd && scanEn) |=> cycleIdx == $past(cycleIdx) + IDX_W'(1)); // R1
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (run && !strb.periodEnd) |=> $stable(cycleIdx)); // R1
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !run |-> cycleIdx == '0); // R7
  AST_STOP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (run && !strb.periodEnd) |=> run); // R10

endmodule

// File: rtl/pixscan_dp.sv
module pixscan_dp
  import pixscan_pkg::*;
#(
  parameter int unsigned DIV_RATIO = 2,
  parameter int unsigned FRAME_LEN = 32,
  localparam int unsigned IDX_W = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  scanStrobe_t       strb,
  input  logic [IDX_W-1:0]  cycleIdx,
  output logic [NUM_CH-1:0] burstQ,
  output logic              doneQ
);

  localparam int unsigned PH_W = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
  localparam int unsigned HALF = DIV_RATIO / 2;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam logic [IDX_W-1:0] LO   = IDX_W'(winLo(g));
    localparam logic [IDX_W-1:0] SPAN = IDX_W'(winHi(g) - winLo(g));

    logic [IDX_W-1:0] offs;
    logic             inWin;
    logic [PH_W:0]    hiLen;

    // Unsigned wrap makes a single compare cover both window bounds
    assign offs  = cycleIdx - LO;
    assign inWin = offs <= SPAN;

    always_ff @(posedge clk) begin
      if (rst) burstQ[g] <= 1'b0;
      else     burstQ[g] <= strb.running && strb.phaseHigh && inWin;
    end

    // High-run length, used only by the width assertion
    always_ff @(posedge clk) begin
      if (rst)            hiLen <= '0;
      else if (burstQ[g]) hiLen <= hiLen + (PH_W+1)'(1);
      else                hiLen <= '0;
    end

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
      $fell(burstQ[g]) |-> hiLen == (PH_W+1)'(HALF)); // R6
  end

  always_ff @(posedge clk) begin
    if (rst) doneQ <= 1'b0;
    else     doneQ <= strb.frameEnd;
  end

  AST_OUT_DISJOINT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(burstQ)); // R5
  AST_LOW_AFTER_PERIOD: assert property (@(posedge clk) disable iff (rst)
    strb.periodEnd |=> burstQ == '0); // R6
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    !strb.running |=> (burstQ == '0 && !doneQ)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    doneQ |=> !doneQ); // R8

endmodule

// File: rtl/pixscan_burst_gen.sv
module pixscan_burst_gen
  import pixscan_pkg::*;
#(
  parameter int unsigned DIV_RATIO = 2,
  parameter int unsigned FRAME_LEN = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         scanEn,
  output logic                         loadClk,
  output logic                         shiftClk,
  output logic                         sampleClk,
  output logic [$clog2(FRAME_LEN)-1:0] cycleIdx,
  output logic                         pixelDone
);

  localparam int unsigned IDX_W = $clog2(FRAME_LEN);

  scanStrobe_t       strb;
  logic [IDX_W-1:0]  idx;
  logic [NUM_CH-1:0] burstQ;

  pixscan_ctrl #(.DIV_RATIO(DIV_RATIO), .FRAME_LEN(FRAME_LEN)) u_ctrl (
    .clk(clk), .rst(rst), .scanEn(scanEn), .strb(strb), .cycleIdx(idx)
  );

  pixscan_dp #(.DIV_RATIO(DIV_RATIO), .FRAME_LEN(FRAME_LEN)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .cycleIdx(idx),
    .burstQ(burstQ), .doneQ(pixelDone)
  );

  assign loadClk   = burstQ[0];
  assign shiftClk  = burstQ[1];
  assign sampleClk = burstQ[2];
  assign cycleIdx  = idx;

endmodule

// File: tb/pixscan_burst_gen_bench.sv
module pixscan_burst_gen_bench;

  localparam int DIV   = 4;
  localparam int HALF  = DIV / 2;
  localparam int FRAME = 32;

  typedef struct { int nLoad; int nShift; int nSample; } frameExp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scanEn = 1'b0;
  logic loadClk, shiftClk, sampleClk, pixelDone;
  logic [4:0] cycleIdx;

  int checks = 0;
  int errs = 0;
  frameExp_t expQ[$];

  always #5 clk = ~clk;

  pixscan_burst_gen #(.DIV_RATIO(DIV), .FRAME_LEN(FRAME)) u_pixscan_burst_gen (
    .clk(clk), .rst(rst), .scanEn(scanEn),
    .loadClk(loadClk), .shiftClk(shiftClk), .sampleClk(sampleClk),
    .cycleIdx(cycleIdx), .pixelDone(pixelDone)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pushFrames(input int n);
    for (int i = 0; i < n; i++) expQ.push_back('{6, 1, 16});
  endtask

  // Monitor: samples 2 ns after each rising edge
  initial begin
    int rises[3];
    int hiLen[3];
    bit prevOut[3];
    bit outs[3];
    int prevIdx;
    int cyc;
    bit sawDone;
    bit prevDone;
    frameExp_t e;
    prevIdx = 0; cyc = 0; sawDone = 0; prevDone = 0;
    for (int c = 0; c < 3; c++) begin rises[c] = 0; hiLen[c] = 0; prevOut[c] = 0; end
    forever begin
      @(posedge clk); #2;
      outs[0] = loadClk; outs[1] = shiftClk; outs[2] = sampleClk;
      if (rst || !scanEn) begin
        for (int c = 0; c < 3; c++) rises[c] = 0;
        cyc = 0; sawDone = 0;
      end
      for (int c = 0; c < 3; c++) begin
        if (outs[c] && !prevOut[c]) rises[c]++;
        if (outs[c]) hiLen[c]++;
        else if (prevOut[c]) begin
          chk(hiLen[c] == HALF, "R6", $sformatf("pulse width ch%0d", c), hiLen[c], HALF);
          hiLen[c] = 0;
        end
      end
      // R5: burst reflects the index of the previous system cycle
      if (outs[0]) chk(prevIdx <= 5, "R5", "load window idx", prevIdx, 5);
      if (outs[1]) chk(prevIdx == 8, "R5", "shift window idx", prevIdx, 8);
      if (outs[2]) chk(prevIdx >= 15 && prevIdx <= 30, "R5", "sample window idx", prevIdx, 15);
      cyc++;
      if (pixelDone) begin
        chk(!prevDone, "R8", "done width", 2, 1);
        chk(cycleIdx == 0, "R8", "idx at done", int'(cycleIdx), 0);
        if (sawDone) chk(cyc == FRAME * DIV, "R1", "frame length", cyc, FRAME * DIV);
        if (expQ.size() == 0) begin
          chk(0, "R8", "unexpected done", 1, 0);
        end else begin
          e = expQ.pop_front();
          chk(rises[0] == e.nLoad, "R2", "load pulses", rises[0], e.nLoad);
          chk(rises[1] == e.nShift, "R3", "shift pulses", rises[1], e.nShift);
          chk(rises[2] == e.nSample, "R4", "sample pulses", rises[2], e.nSample);
        end
        for (int c = 0; c < 3; c++) rises[c] = 0;
        cyc = 0; sawDone = 1;
      end
      prevDone = pixelDone;
      prevIdx = int'(cycleIdx);
      for (int c = 0; c < 3; c++) prevOut[c] = outs[c];
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("%0d/%0d checks passed", checks - errs, checks);
    $finish;
  end

  // Driver
  initial begin
    bit quiet;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({loadClk, shiftClk, sampleClk, pixelDone} == 4'b0 && cycleIdx == 0,
        "R7", "reset state", int'({loadClk, shiftClk, sampleClk, pixelDone}), 0);
    rst = 1'b0;
    quiet = 1;
    repeat (8) begin
      @(negedge clk);
      if ({loadClk, shiftClk, sampleClk, pixelDone} != 4'b0 || cycleIdx != 0) quiet = 0;
    end
    chk(quiet, "R7", "idle with enable low", int'(quiet), 1);

    pushFrames(3);
    scanEn = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(!loadClk, "R9", "load after first edge", int'(loadClk), 0);
    chk(cycleIdx == 0, "R9", "idx at start", int'(cycleIdx), 0);
    @(posedge clk); @(negedge clk);
    chk(loadClk, "R9", "load after second edge", int'(loadClk), 1);

    while (expQ.size() > 0) @(negedge clk);
    repeat (42) @(negedge clk);
    scanEn = 1'b0;
    repeat (DIV + 1) @(negedge clk);
    chk(cycleIdx == 0, "R10", "idx after disable", int'(cycleIdx), 0);
    chk({loadClk, shiftClk, sampleClk} == 3'b0, "R10", "outputs after disable",
        int'({loadClk, shiftClk, sampleClk}), 0);
    quiet = 1;
    repeat (30) begin
      @(negedge clk);
      if ({loadClk, shiftClk, sampleClk, pixelDone} != 4'b0 || cycleIdx != 0) quiet = 0;
    end
    chk(quiet, "R10", "stays idle", int'(quiet), 1);

    pushFrames(1);
    scanEn = 1'b1;
    while (expQ.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(cycleIdx == 0 || cycleIdx == 1, "R1", "idx after wrap", int'(cycleIdx), 0);
    scanEn = 1'b0;
    repeat (2 * DIV) @(negedge clk);
    $display("%0d/%0d checks passed", checks - errs, checks);
    $finish;
  end

endmodule